// File: doc/BRIEF.md
# Binary Match Store with Validity and Chained Status

`bcam_stat` is a binary content-addressable store of 64-bit words, `DEPTH` entries deep (16 by default). Every entry carries a validity bit. The host reaches the store over a 32-bit data path, and a half-select input picks the low or the high half of a word.

The block supports these operations:
- random read and random write of one half at a given address;
- loading of a comparand one half at a time;
- a compare of the full 64-bit comparand against every valid entry;
- a write into the lowest free entry;
- a read or write of the best match found by the last compare.

The status word combines three active-low flags with the device's page number and an entry address. The flags are match, multiple match and full.

Several devices can form a vertical chain. A chain input tells each device that some higher device has matched, and a second input tells it that every higher device is full. The device passes both signals down the chain after adding its own state. A status-drive output then lets exactly one device in the chain present its status.

The sequencer has five states:
- `ST_IDLE`: no status is driven. It is entered from reset and by a comparand load.
- `ST_RAND`: entered by a random read or write.
- `ST_CMP`: entered by a compare.
- `ST_NF`: entered by a next-free write.
- `ST_HP`: entered by a best-match read or write.

A no-op, or any cycle with `sel` low, keeps the current state. This lets the status-drive decision persist across idle cycles.

Top module: `bcam_stat`

## Requirements
- R1: After reset, no entry is valid. `status[31]` (match_n), `status[30]` (mult_n) and `status[29]` (full_n) are all 1. `stat_oe` is 0, `rdata` is 0 and `rvalid_n` is 1.
- R2: Op codes are 0 no-op, 1 read, 2 write, 3 load comparand, 4 compare, 5 next-free write, 6 best-match read, 7 best-match write. `half`=0 selects bits 31:0 and `half`=1 selects bits 63:32. A write (2) stores `wdata` into the chosen half at `addr` and sets the entry's validity to `~wvalid_n`. A read (1) returns that half on `rdata` and the entry's validity, active low, on `rvalid_n`, one cycle later.
- R3: Load (3) and compare (4) both replace the chosen half of the comparand with `wdata`. Compare (4) then matches the whole 64-bit comparand against valid entries only. Invalid entries never match. `status[31]` goes low when any entry matches.
- R4: The best match is the lowest-indexed matching entry. After a compare, `status[AW-1:0]` holds its index, or 0 on a miss. `status[AW+PW-1:AW]` always shows `page_id`. After a random op, the address field shows `addr`.
- R5: `status[30]` goes low after a compare in which two or more valid entries match.
- R6: Next-free write (5) is carried out only when `casc_full_n_in` is 0 and the device is not full. It writes the chosen half of the lowest-indexed invalid entry. The high half also marks that entry valid. Otherwise it changes nothing.
- R7: `status[29]` is 0 exactly when all entries are valid. `casc_full_n_out` is 0 only when both `casc_full_n_in` and the local full flag are 0.
- R8: After a compare, `stat_oe` is 1 in two cases. The first is a local match while `casc_match_n_in` is 1. The second is no local match, `casc_match_n_in` 1, and `last_dev` 1.
- R9: `stat_oe` is 1 after a random read or write. After a next-free write it is 1 only if the write took place. After a comparand load it is 0.
- R10: Best-match read (6) returns the chosen half of the last best-match entry when the last compare matched. Best-match write (7) writes there only when the last compare matched and `casc_match_n_in` is 1. After either op, `stat_oe` is 1 under the same two conditions.
- R11: `casc_match_n_out` is 0 when `casc_match_n_in` is 0 or the last compare matched locally.
- R12: While `sel` is 0, no operation changes any entry, the comparand, `rdata` or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Device select; the op is ignored when low |
| op | input | 3 | Operation code |
| half | input | 1 | Half select: 0 low word, 1 high word |
| addr | input | AW | Entry address for random ops |
| wdata | input | 32 | Write data or comparand half |
| wvalid_n | input | 1 | Validity for random write, active low |
| page_id | input | PW | Page number of this device |
| casc_match_n_in | input | 1 | A higher device matched (active low) |
| casc_full_n_in | input | 1 | All higher devices are full (active low) |
| last_dev | input | 1 | This is the lowest-priority device |
| rdata | output | 32 | Read data |
| rvalid_n | output | 1 | Validity of the entry read, active low |
| status | output | 32 | Flags, page and address |
| stat_oe | output | 1 | This device should drive its status |
| casc_match_n_out | output | 1 | Chained match indication downward |
| casc_full_n_out | output | 1 | Chained full indication downward |

## Verification
The bench builds a compare in which the same key sits in two valid entries and in one invalid entry. A design that compares invalid entries, or picks the higher index, would report the wrong address or a wrong multiple-match flag.

It then overwrites the best-match entry and compares again. A design that updates its flags from stale state would leave the multiple-match flag low.

Next-free writes are issued three ways:
- while a higher device is not yet full, where a design that ignores the chain input would steal the write;
- normally, with the low half first, where a design that validates on the low half would let a later write skip a slot;
- into a full array, where an unguarded design would overwrite entry 0.

A best-match write is also issued while a higher device has matched. Any change at that address then shows in a later read-back.

// File: rtl/bcam_pkg.sv
package bcam_pkg;

    localparam int HALF_W = 32;
    localparam int WORD_W = 2 * HALF_W;
    localparam int STAT_W = 32;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_LDC = 3'd3,
        OP_CMP = 3'd4,
        OP_WNF = 3'd5,
        OP_RHP = 3'd6,
        OP_WHP = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RAND = 3'd1,
        ST_CMP  = 3'd2,
        ST_NF   = 3'd3,
        ST_HP   = 3'd4
    } state_e;

endpackage

// File: rtl/bcam_prio.sv
// Lowest-index-first priority encoder.
module bcam_prio #(
    parameter int N = 16,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/bcam_store.sv
// Entry storage, validity bits and per-entry comparators.
module bcam_store
    import bcam_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wr_half,
    input  logic [AW-1:0]     wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              val_we,
    input  logic              val_d,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_half,
    input  logic [WORD_W-1:0] key,
    output logic [HALF_W-1:0] rd_word,
    output logic              rd_val,
    output logic [DEPTH-1:0]  valid,
    output logic [DEPTH-1:0]  hit
);
    logic [HALF_W-1:0] lo_bus [DEPTH];
    logic [HALF_W-1:0] hi_bus [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [HALF_W-1:0] lo_q;
        logic [HALF_W-1:0] hi_q;
        logic              v_q;
        logic              sel_me;

        assign sel_me = (wr_addr == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
                v_q  <= 1'b0;
            end else begin
                if (we && sel_me) begin
                    if (wr_half) hi_q <= wr_data;
                    else         lo_q <= wr_data;
                end
                if (val_we && sel_me) v_q <= val_d;
            end
        end

        assign lo_bus[g] = lo_q;
        assign hi_bus[g] = hi_q;
        assign valid[g]  = v_q;
        assign hit[g]    = v_q && ({hi_q, lo_q} == key);
    end

    assign rd_word = rd_half ? hi_bus[rd_addr] : lo_bus[rd_addr];
    assign rd_val  = valid[rd_addr];
endmodule

// File: rtl/bcam_seq.sv
// Operation sequencer: decodes ops, holds status and drives the chain.
module bcam_seq
    import bcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int PADW = STAT_W - 3 - PW - AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  op_e               op,
    input  logic              half,
    input  logic [AW-1:0]     addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              wvalid_n,
    input  logic [PW-1:0]     page_id,
    input  logic              casc_match_n_in,
    input  logic              casc_full_n_in,
    input  logic              last_dev,
    input  logic              full_n,
    input  logic [AW-1:0]     free_idx,
    input  logic              hit_any,
    input  logic [AW-1:0]     hit_first,
    input  logic              hit_multi,
    input  logic [HALF_W-1:0] rd_word,
    input  logic              rd_val,
    output logic              st_we,
    output logic [AW-1:0]     st_addr,
    output logic              st_val_we,
    output logic              st_val_d,
    output logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] key,
    output logic [HALF_W-1:0] rdata,
    output logic              rvalid_n,
    output logic [STAT_W-1:0] status,
    output logic              stat_oe,
    output logic              casc_match_n_out,
    output logic              casc_full_n_out
);
    state_e            state_q, state_d;
    logic [WORD_W-1:0] cmp_q;
    logic              match_n_q, mult_n_q, nf_hit_q, rvalid_n_q;
    logic [AW-1:0]     sa_q, hp_q;
    logic [HALF_W-1:0] rdata_q;
    logic              nf_ok, hp_ok;

    assign nf_ok   = ~casc_full_n_in & full_n;
    assign hp_ok   = ~match_n_q;
    assign key     = half ? {wdata, cmp_q[HALF_W-1:0]} : {cmp_q[WORD_W-1:HALF_W], wdata};
    assign rd_addr = (op == OP_RHP) ? hp_q : addr;

    // Next state and storage controls
    always_comb begin
        state_d   = state_q;
        st_we     = 1'b0;
        st_addr   = addr;
        st_val_we = 1'b0;
        st_val_d  = 1'b0;
        if (sel) begin
            unique case (op)
                OP_NOP: ;
                OP_RD:  state_d = ST_RAND;
                OP_WR: begin
                    st_we     = 1'b1;
                    st_val_we = 1'b1;
                    st_val_d  = ~wvalid_n;
                    state_d   = ST_RAND;
                end
                OP_LDC: state_d = ST_IDLE;
                OP_CMP: state_d = ST_CMP;
                OP_WNF: begin
                    st_we     = nf_ok;
                    st_addr   = free_idx;
                    st_val_we = nf_ok & half;
                    st_val_d  = 1'b1;
                    state_d   = ST_NF;
                end
                OP_RHP: state_d = ST_HP;
                OP_WHP: begin
                    st_we   = hp_ok & casc_match_n_in;
                    st_addr = hp_q;
                    state_d = ST_HP;
                end
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q      <= '0;
            match_n_q  <= 1'b1;
            mult_n_q   <= 1'b1;
            nf_hit_q   <= 1'b0;
            sa_q       <= '0;
            hp_q       <= '0;
            rdata_q    <= '0;
            rvalid_n_q <= 1'b1;
        end else if (sel) begin
            unique case (op)
                OP_NOP: ;
                OP_RD: begin
                    rdata_q    <= rd_word;
                    rvalid_n_q <= ~rd_val;
                    sa_q       <= addr;
                end
                OP_WR:  sa_q  <= addr;
                OP_LDC: cmp_q <= key;
                OP_CMP: begin
                    cmp_q     <= key;
                    match_n_q <= ~hit_any;
                    mult_n_q  <= ~hit_multi;
                    sa_q      <= hit_any ? hit_first : '0;
                    hp_q      <= hit_any ? hit_first : '0;
                end
                OP_WNF: begin
                    nf_hit_q <= nf_ok;
                    if (nf_ok) sa_q <= free_idx;
                end
                OP_RHP: begin
                    sa_q <= hp_q;
                    if (hp_ok) begin
                        rdata_q    <= rd_word;
                        rvalid_n_q <= ~rd_val;
                    end
                end
                OP_WHP: sa_q <= hp_q;
                default: ;
            endcase
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            ST_IDLE: stat_oe = 1'b0;
            ST_RAND: stat_oe = 1'b1;
            ST_CMP:  stat_oe = casc_match_n_in & (~match_n_q | last_dev);
            ST_NF:   stat_oe = nf_hit_q;
            ST_HP:   stat_oe = ~match_n_q & casc_match_n_in;
            default: stat_oe = 1'b0;
        endcase
    end

    assign status           = {match_n_q, mult_n_q, full_n, {PADW{1'b0}}, page_id, sa_q};
    assign rdata            = rdata_q;
    assign rvalid_n         = rvalid_n_q;
    assign casc_match_n_out = casc_match_n_in & match_n_q;
    assign casc_full_n_out  = casc_full_n_in | full_n;
endmodule

// File: rtl/bcam_stat.sv
module bcam_stat
    import bcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [2:0]    op,
    input  logic          half,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic          wvalid_n,
    input  logic [PW-1:0] page_id,
    input  logic          casc_match_n_in,
    input  logic          casc_full_n_in,
    input  logic          last_dev,
    output logic [31:0]   rdata,
    output logic          rvalid_n,
    output logic [31:0]   status,
    output logic          stat_oe,
    output logic          casc_match_n_out,
    output logic          casc_full_n_out
);
    logic              st_we, st_val_we, st_val_d, rd_val;
    logic [AW-1:0]     st_addr, rd_addr, free_idx, hit_first;
    logic [WORD_W-1:0] key;
    logic [HALF_W-1:0] rd_word;
    logic [DEPTH-1:0]  valid, hit;
    logic              free_any, hit_any, hit_multi;

    bcam_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .wr_half (half),
        .wr_addr (st_addr),
        .wr_data (wdata),
        .val_we  (st_val_we),
        .val_d   (st_val_d),
        .rd_addr (rd_addr),
        .rd_half (half),
        .key     (key),
        .rd_word (rd_word),
        .rd_val  (rd_val),
        .valid   (valid),
        .hit     (hit)
    );

    bcam_prio #(.N(DEPTH)) u_free (
        .vec (~valid),
        .idx (free_idx),
        .any (free_any)
    );

    bcam_prio #(.N(DEPTH)) u_hit (
        .vec (hit),
        .idx (hit_first),
        .any (hit_any)
    );

    assign hit_multi = |(hit & (hit - DEPTH'(1)));

    bcam_seq #(.DEPTH(DEPTH), .PW(PW)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .sel              (sel),
        .op               (op_e'(op)),
        .half             (half),
        .addr             (addr),
        .wdata            (wdata),
        .wvalid_n         (wvalid_n),
        .page_id          (page_id),
        .casc_match_n_in  (casc_match_n_in),
        .casc_full_n_in   (casc_full_n_in),
        .last_dev         (last_dev),
        .full_n           (free_any),
        .free_idx         (free_idx),
        .hit_any          (hit_any),
        .hit_first        (hit_first),
        .hit_multi        (hit_multi),
        .rd_word          (rd_word),
        .rd_val           (rd_val),
        .st_we            (st_we),
        .st_addr          (st_addr),
        .st_val_we        (st_val_we),
        .st_val_d         (st_val_d),
        .rd_addr          (rd_addr),
        .key              (key),
        .rdata            (rdata),
        .rvalid_n         (rvalid_n),
        .status           (status),
        .stat_oe          (stat_oe),
        .casc_match_n_out (casc_match_n_out),
        .casc_full_n_out  (casc_full_n_out)
    );
endmodule

// File: rtl/bcam_stat_chk.sv
module bcam_stat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic [2:0]  op,
    input logic [31:0] rdata,
    input logic        flag_match_n,
    input logic        flag_mult_n,
    input logic        flag_full_n,
    input logic        stat_oe,
    input logic        casc_match_n_in,
    input logic        casc_match_n_out,
    input logic        casc_full_n_out
);
    import bcam_pkg::*;

    assert_mult_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_mult_n |-> !flag_match_n);

    assert_chain_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_match_n_in |-> !casc_match_n_out);

    assert_chain_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_full_n_out |-> !flag_full_n);

    assert_unselected_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(rdata));

    assert_load_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_LDC) |=> !stat_oe);

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_WNF && !flag_full_n) |=> !flag_full_n);
endmodule

bind bcam_stat bcam_stat_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .sel              (sel),
    .op               (op),
    .rdata            (rdata),
    .flag_match_n     (status[31]),
    .flag_mult_n      (status[30]),
    .flag_full_n      (status[29]),
    .stat_oe          (stat_oe),
    .casc_match_n_in  (casc_match_n_in),
    .casc_match_n_out (casc_match_n_out),
    .casc_full_n_out  (casc_full_n_out)
);

// File: tb/test_bcam_stat.sv
module test_bcam_stat;
    localparam int P     = 10;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int PW    = 4;

    localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, LDC = 3'd3,
                           CMP = 3'd4, WNF = 3'd5, RHP = 3'd6, WHP = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic [2:0]    op = '0;
    logic          half = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wvalid_n = 1'b1;
    logic [PW-1:0] page_id = 4'hA;
    logic          casc_match_n_in = 1'b1;
    logic          casc_full_n_in = 1'b0;
    logic          last_dev = 1'b1;
    logic [31:0]   rdata;
    logic          rvalid_n;
    logic [31:0]   status;
    logic          stat_oe;
    logic          casc_match_n_out;
    logic          casc_full_n_out;

    logic nxt_cmi = 1'b1, nxt_cfi = 1'b0, nxt_last = 1'b1;

    bcam_stat i_bcam_stat (
        .clk(clk), .rst_n(rst_n), .sel(sel), .op(op), .half(half), .addr(addr),
        .wdata(wdata), .wvalid_n(wvalid_n), .page_id(page_id),
        .casc_match_n_in(casc_match_n_in), .casc_full_n_in(casc_full_n_in),
        .last_dev(last_dev), .rdata(rdata), .rvalid_n(rvalid_n), .status(status),
        .stat_oe(stat_oe), .casc_match_n_out(casc_match_n_out),
        .casc_full_n_out(casc_full_n_out)
    );

    always #(P/2) clk = ~clk;

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic        rvn;
        logic [31:0] st;
        logic        oe;
        logic        cmo;
        logic        cfo;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Reference model state
    logic [31:0]      m_lo [DEPTH];
    logic [31:0]      m_hi [DEPTH];
    logic [DEPTH-1:0] m_val = '0;
    logic [63:0]      m_cmp = '0;
    logic             m_mn = 1'b1, m_mm = 1'b1, m_nf = 1'b0, m_rvn = 1'b1;
    logic [AW-1:0]    m_sa = '0, m_hp = '0;
    logic [31:0]      m_rd = '0;
    int               m_st = 0;

    task automatic mwrite(input logic [AW-1:0] a, input logic h, input logic [31:0] d);
        if (h) m_hi[a] = d;
        else   m_lo[a] = d;
    endtask

    task automatic apply(input logic s, input logic [2:0] o, input logic h,
                         input logic [AW-1:0] a, input logic [31:0] d,
                         input logic vbn, input string tag);
        exp_t        e;
        logic [63:0] key;
        int          cnt;
        int          first;
        int          fr;
        logic        ok;
        @(negedge clk);
        sel = s; op = o; half = h; addr = a; wdata = d; wvalid_n = vbn;
        casc_match_n_in = nxt_cmi; casc_full_n_in = nxt_cfi; last_dev = nxt_last;
        @(posedge clk);
        key = h ? {d, m_cmp[31:0]} : {m_cmp[63:32], d};
        ok  = !nxt_cfi && !(&m_val);
        if (s) begin
            case (o)
                RD: begin
                    m_rd = h ? m_hi[a] : m_lo[a]; m_rvn = !m_val[a]; m_sa = a; m_st = 1;
                end
                WR: begin
                    mwrite(a, h, d); m_val[a] = !vbn; m_sa = a; m_st = 1;
                end
                LDC: begin
                    m_cmp = key; m_st = 0;
                end
                CMP: begin
                    m_cmp = key; cnt = 0; first = 0;
                    for (int i = DEPTH - 1; i >= 0; i--) begin
                        if (m_val[i] && {m_hi[i], m_lo[i]} == key) begin
                            cnt++; first = i;
                        end
                    end
                    m_mn = (cnt == 0); m_mm = !(cnt > 1);
                    m_sa = AW'(first); m_hp = AW'(first); m_st = 2;
                end
                WNF: begin
                    m_nf = ok; m_st = 3;
                    if (ok) begin
                        fr = 0;
                        for (int i = DEPTH - 1; i >= 0; i--) if (!m_val[i]) fr = i;
                        mwrite(AW'(fr), h, d);
                        if (h) m_val[fr] = 1'b1;
                        m_sa = AW'(fr);
                    end
                end
                RHP: begin
                    if (!m_mn) begin
                        m_rd = h ? m_hi[m_hp] : m_lo[m_hp]; m_rvn = !m_val[m_hp];
                    end
                    m_sa = m_hp; m_st = 4;
                end
                WHP: begin
                    if (!m_mn && nxt_cmi) mwrite(m_hp, h, d);
                    m_sa = m_hp; m_st = 4;
                end
                default: ;
            endcase
        end
        e.tag = tag;
        e.rd  = m_rd;
        e.rvn = m_rvn;
        e.st  = {m_mn, m_mm, !(&m_val), 21'b0, page_id, m_sa};
        case (m_st)
            1:       e.oe = 1'b1;
            2:       e.oe = nxt_cmi && (!m_mn || nxt_last);
            3:       e.oe = m_nf;
            4:       e.oe = !m_mn && nxt_cmi;
            default: e.oe = 1'b0;
        endcase
        e.cmo = nxt_cmi && m_mn;
        e.cfo = nxt_cfi || !(&m_val);
        q.push_back(e);
    endtask

    // Monitor: compares outputs a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(P/4);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (rdata !== e.rd || rvalid_n !== e.rvn || status !== e.st ||
                    stat_oe !== e.oe || casc_match_n_out !== e.cmo ||
                    casc_full_n_out !== e.cfo) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h rvn=%b status=%h oe=%b cmo=%b cfo=%b expected rdata=%h rvn=%b status=%h oe=%b cmo=%b cfo=%b",
                             e.tag, rdata, rvalid_n, status, stat_oe, casc_match_n_out,
                             casc_full_n_out, e.rd, e.rvn, e.st, e.oe, e.cmo, e.cfo);
                end
            end
        end
    end

    initial begin
        #(P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_lo[i] = '0; m_hi[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        apply(0, NOP, 0, 0, 0, 1, "R1 reset state");

        apply(1, WR, 0, 3, 32'hAAAA_0001, 0, "R2 write lo");
        apply(1, WR, 1, 3, 32'hBBBB_0002, 0, "R2 write hi");
        apply(1, RD, 0, 3, 0, 1, "R2 read lo");
        apply(1, RD, 1, 3, 0, 1, "R2 R9 read hi");
        apply(1, WR, 0, 7, 32'hAAAA_0001, 0, "R2");
        apply(1, WR, 1, 7, 32'hBBBB_0002, 0, "R2");
        apply(1, WR, 0, 5, 32'hAAAA_0001, 1, "R2 invalid entry");
        apply(1, WR, 1, 5, 32'hBBBB_0002, 1, "R2 invalid entry");
        apply(1, RD, 0, 5, 0, 1, "R2 invalid readback");

        apply(1, LDC, 0, 0, 32'hAAAA_0001, 1, "R9 load quiet");
        apply(1, CMP, 1, 0, 32'hBBBB_0002, 1, "R3 R4 R5 double match");
        apply(1, RHP, 1, 0, 0, 1, "R10 best read");

        nxt_cmi = 1'b0;
        apply(1, WHP, 0, 0, 32'hDEAD_0000, 1, "R10 R11 best write blocked");
        nxt_cmi = 1'b1;
        apply(1, RD, 0, 3, 0, 1, "R10 entry kept");
        apply(1, WHP, 0, 0, 32'hCCCC_0003, 1, "R10 best write");
        apply(1, RD, 0, 3, 0, 1, "R10 entry written");
        apply(1, CMP, 1, 0, 32'hBBBB_0002, 1, "R4 R5 single match");

        apply(1, LDC, 0, 0, 32'h1234_0000, 1, "R9");
        apply(1, CMP, 1, 0, 32'h0000_5678, 1, "R8 miss last device");
        nxt_last = 1'b0;
        apply(1, NOP, 0, 0, 0, 1, "R8 miss not last");
        nxt_last = 1'b1;

        nxt_cfi = 1'b1;
        apply(1, WNF, 0, 0, 32'h9999_9999, 1, "R6 higher not full");
        nxt_cfi = 1'b0;
        apply(1, RD, 0, 0, 0, 1, "R6 no write");
        apply(1, WNF, 0, 0, 32'hD000_0010, 1, "R6 R9 free lo");
        apply(1, WNF, 1, 0, 32'hD000_0011, 1, "R6 free hi");
        apply(1, RD, 1, 0, 0, 1, "R6 readback");
        apply(1, WNF, 0, 0, 32'hE000_0020, 1, "R6 next slot");
        apply(1, WNF, 1, 0, 32'hE000_0021, 1, "R6 next slot hi");

        apply(0, WR, 0, 2, 32'hFFFF_FFFF, 0, "R12 unselected write");
        apply(1, RD, 0, 2, 0, 1, "R12 readback");

        for (int i = 0; i < DEPTH; i++) begin
            apply(1, WR, 1, AW'(i), 32'h5000_0000 + i, 0, "R7 fill");
        end
        nxt_cfi = 1'b1;
        apply(1, NOP, 0, 0, 0, 1, "R7 chain full blocked");
        nxt_cfi = 1'b0;
        apply(1, WNF, 0, 0, 32'h7777_7777, 1, "R6 R7 write when full");
        apply(1, RD, 0, 0, 0, 1, "R6 full untouched");
        apply(1, WR, 1, 9, 0, 1, "R7 free again");

        @(negedge clk);
        sel = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule